// File: doc/BRIEF.md
# Saturating Signed Adder/Subtractor

This block adds or subtracts two two's complement operands of a parameterised width, which is 16 bits by default. Overflow is decided from sign bits alone. For addition, the test is the signs of the two operands against the sign of the result. For subtraction, the second operand is negated by complementing it and injecting a carry, and the same test is then applied. The caller chooses whether an overflowed result wraps modulo 2^N or is clamped to the representable limits.

A symmetric-limit option narrows the negative rail to −(2^(N−1)−1). With it, positive and negative clamping errors balance when results are accumulated downstream. All three outputs are registered and appear one clock after the operands are presented:

- the result;
- a raw overflow flag;
- a flag that reports when clamping actually altered the output.

Top module: `sat_addsub`

## Requirements
- R1: With `sat_en`=0 and `sub_sel`=0, `res` equals (`op_a` + `op_b`) mod 2^N.
- R2: With `sat_en`=0 and `sub_sel`=1, `res` equals (`op_a` − `op_b`) mod 2^N.
- R3: For addition, `ovf` is 1 exactly when both operands have the same sign bit and the wrapped sum's sign bit differs from it.
- R4: For subtraction, `ovf` is 1 exactly when the operand sign bits differ and the wrapped difference's sign bit differs from that of `op_a`.
- R5: With `sat_en`=1, an overflow whose true result is positive (that is, `op_a` sign bit 0) yields `res` = 2^(N−1)−1 (16'h7FFF at 16 bits).
- R6: With `sat_en`=1 and `sym_lim`=0, an overflow whose true result is negative yields `res` = −2^(N−1) (16'h8000).
- R7: With `sat_en`=1 and `sym_lim`=1, an overflow whose true result is negative yields `res` = −(2^(N−1)−1) (16'h8001).
- R8: With `sat_en`=1 and `sym_lim`=1, a result that does not overflow but equals −2^(N−1) is output as −(2^(N−1)−1) (16'h8001). With `sym_lim`=0 it is passed through unchanged.
- R9: `ovf` reports the raw overflow condition whatever the value of `sat_en`.
- R10: `sat` is 1 exactly when clamping made `res` differ from the wrapped result; it is always 0 when `sat_en`=0.
- R11: Outputs update on the rising clock edge that samples the inputs, and hold between edges.
- R12: While `rst_n` is low, `res`, `ovf` and `sat` are 0, independent of the clock.
- R13: With `sat_en`=0, `sym_lim` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | WIDTH | First signed operand |
| op_b | input | WIDTH | Second signed operand |
| sub_sel | input | 1 | 1 selects op_a − op_b, 0 selects op_a + op_b |
| sat_en | input | 1 | 1 clamps on overflow, 0 wraps |
| sym_lim | input | 1 | 1 uses the symmetric negative limit when clamping |
| res | output | WIDTH | Registered result |
| ovf | output | 1 | Registered raw overflow flag |
| sat | output | 1 | Registered flag: clamping changed the result |

## Verification
The bench checks cases where each rule goes wrong in a specific way:

- **Subtracting the most negative value.** A wrong negation step would miss the overflow of 0 − (−2^(N−1)), or would flag −1 − (−2^(N−1)) falsely.
- **Adding the most negative value to itself.** The wrapped sum is zero and carries no sign hint, so a design that tested the wrong bit would clamp to the wrong rail.
- **A plain −2^(N−1) under the symmetric limit.** A design that only clamped overflows would emit 16'h8000 with `sat` low here.
- **Saturation disabled.** These vectors catch a design that clamps anyway, that hides `ovf`, or that lets `sym_lim` alter the output.

// File: rtl/sat_addsub_pkg.sv
package sat_addsub_pkg;

  // Direction of an overflow, decided from sign bits only
  typedef enum logic [1:0] {
    OVF_NONE = 2'b00,
    OVF_POS  = 2'b01,
    OVF_NEG  = 2'b10
  } ovf_kind_e;

endpackage

// File: rtl/sat_addsub_core.sv
module sat_addsub_core
  import sat_addsub_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output ovf_kind_e        kind_o
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic             same_sign;
  logic             flipped;

  // Negation as complement plus an injected carry
  always_comb begin
    b_eff = b_i ^ {WIDTH{sub_i}};
    sum_o = a_i + b_eff + {{(WIDTH-1){1'b0}}, sub_i};
  end

  // One sign-bit test serves both operations
  always_comb begin
    same_sign = (a_i[MSB] == b_eff[MSB]);
    flipped   = (sum_o[MSB] != a_i[MSB]);
    if (same_sign && flipped) begin
      kind_o = a_i[MSB] ? OVF_NEG : OVF_POS;
    end else begin
      kind_o = OVF_NONE;
    end
  end

endmodule

// File: rtl/sat_addsub_limit.sv
module sat_addsub_limit
  import sat_addsub_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] sum_i,
  input  ovf_kind_e        kind_i,
  input  logic             sat_en_i,
  input  logic             sym_i,
  output logic [WIDTH-1:0] res_o,
  output logic             clamped_o
);

  localparam logic [WIDTH-1:0] RAIL_HI  = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic [WIDTH-1:0] RAIL_LO  = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [WIDTH-1:0] RAIL_SYM = {1'b1, {(WIDTH-2){1'b0}}, 1'b1};

  logic [WIDTH-1:0] neg_rail;

  always_comb begin
    neg_rail  = sym_i ? RAIL_SYM : RAIL_LO;
    res_o     = sum_i;
    clamped_o = 1'b0;
    if (sat_en_i) begin
      unique case (kind_i)
        OVF_POS: begin
          res_o     = RAIL_HI;
          clamped_o = 1'b1;
        end
        OVF_NEG: begin
          res_o     = neg_rail;
          clamped_o = 1'b1;
        end
        default: begin
          // In-range result sitting on the unbalanced rail
          if (sym_i && (sum_i == RAIL_LO)) begin
            res_o     = RAIL_SYM;
            clamped_o = 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/sat_addsub.sv
module sat_addsub
  import sat_addsub_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             sub_sel,
  input  logic             sat_en,
  input  logic             sym_lim,
  output logic [WIDTH-1:0] res,
  output logic             ovf,
  output logic             sat
);

  localparam int               MSB     = WIDTH - 1;
  localparam logic [WIDTH-1:0] TOP_VAL = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic [WIDTH-1:0] BOT_VAL = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [WIDTH-1:0] SYM_VAL = {1'b1, {(WIDTH-2){1'b0}}, 1'b1};

  logic [WIDTH-1:0] sum_w;
  ovf_kind_e        kind_w;
  logic [WIDTH-1:0] res_d;
  logic             clamp_w;
  logic             ovf_d;
  logic             sat_d;

  sat_addsub_core #(.WIDTH(WIDTH)) u_core (
    .a_i   (op_a),
    .b_i   (op_b),
    .sub_i (sub_sel),
    .sum_o (sum_w),
    .kind_o(kind_w)
  );

  sat_addsub_limit #(.WIDTH(WIDTH)) u_limit (
    .sum_i    (sum_w),
    .kind_i   (kind_w),
    .sat_en_i (sat_en),
    .sym_i    (sym_lim),
    .res_o    (res_d),
    .clamped_o(clamp_w)
  );

  // Next-state
  always_comb begin
    ovf_d = (kind_w != OVF_NONE);
    sat_d = clamp_w;
  end

  // Register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res <= '0;
      ovf <= 1'b0;
      sat <= 1'b0;
    end else begin
      res <= res_d;
      ovf <= ovf_d;
      sat <= sat_d;
    end
  end

  // R3: an addition overflow needs operands of equal sign
  p_add_ovf_signs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !$past(sub_sel)) |-> ($past(op_a[MSB]) == $past(op_b[MSB])));

  // R4: a subtraction overflow needs operands of opposite sign
  p_sub_ovf_signs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && $past(sub_sel)) |-> ($past(op_a[MSB]) != $past(op_b[MSB])));

  // R5: a clamped non-negative output is the top rail
  p_pos_rail_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sat && !res[MSB]) |-> (res == TOP_VAL));

  // R7 and R8: the symmetric limit never lets the bottom code out
  p_sym_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sat_en && sym_lim) |-> (res != BOT_VAL));

  // R10: a clamp always lands on one of the rails
  p_sat_on_rail_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sat |-> (res == TOP_VAL || res == BOT_VAL || res == SYM_VAL));

  // R10: wrap mode never reports a clamp
  p_wrap_no_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!sat_en) |-> !sat);

  // R8: a clamp without overflow happens only under the symmetric limit
  p_sat_without_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sat && !ovf) |-> ($past(sym_lim) && res == SYM_VAL));

endmodule

// File: tb/sat_addsub_bench.sv
`timescale 1ns/1ps
module sat_addsub_bench;

  localparam int W = 16;

  typedef struct packed {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         sub;
    logic         sen;
    logic         sym;
    logic [W-1:0] res;
    logic         ovf;
    logic         sat;
    logic [7:0]   req;
  } vec_t;

  localparam int NV = 21;
  // Fields: a, b, sub, sat_en, sym_lim, expected res, ovf, sat, requirement number
  localparam vec_t VECS [NV] = '{
    '{16'h1234, 16'h0001, 1'b0, 1'b0, 1'b0, 16'h1235, 1'b0, 1'b0, 8'd1},  // R1
    '{16'h7FFF, 16'h0001, 1'b0, 1'b0, 1'b0, 16'h8000, 1'b1, 1'b0, 8'd9},  // R9 R1
    '{16'h8000, 16'hFFFF, 1'b0, 1'b0, 1'b0, 16'h7FFF, 1'b1, 1'b0, 8'd3},  // R3
    '{16'h7FFF, 16'h0001, 1'b0, 1'b1, 1'b0, 16'h7FFF, 1'b1, 1'b1, 8'd5},  // R5
    '{16'h8000, 16'hFFFF, 1'b0, 1'b1, 1'b0, 16'h8000, 1'b1, 1'b1, 8'd6},  // R6
    '{16'h8000, 16'hFFFF, 1'b0, 1'b1, 1'b1, 16'h8001, 1'b1, 1'b1, 8'd7},  // R7
    '{16'h4000, 16'hC000, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 8'd3},  // R3
    '{16'h0005, 16'h0003, 1'b1, 1'b0, 1'b0, 16'h0002, 1'b0, 1'b0, 8'd2},  // R2
    '{16'h0000, 16'h8000, 1'b1, 1'b0, 1'b0, 16'h8000, 1'b1, 1'b0, 8'd4},  // R4
    '{16'h0000, 16'h8000, 1'b1, 1'b1, 1'b0, 16'h7FFF, 1'b1, 1'b1, 8'd5},  // R5
    '{16'h8000, 16'h0001, 1'b1, 1'b0, 1'b0, 16'h7FFF, 1'b1, 1'b0, 8'd4},  // R4
    '{16'h8000, 16'h0001, 1'b1, 1'b1, 1'b1, 16'h8001, 1'b1, 1'b1, 8'd7},  // R7
    '{16'hFFFF, 16'h8000, 1'b1, 1'b0, 1'b0, 16'h7FFF, 1'b0, 1'b0, 8'd4},  // R4
    '{16'hFFFF, 16'h8001, 1'b0, 1'b1, 1'b1, 16'h8001, 1'b0, 1'b1, 8'd8},  // R8
    '{16'hFFFF, 16'h8001, 1'b0, 1'b1, 1'b0, 16'h8000, 1'b0, 1'b0, 8'd8},  // R8
    '{16'hFFFF, 16'h8001, 1'b0, 1'b0, 1'b1, 16'h8000, 1'b0, 1'b0, 8'd13}, // R13
    '{16'h7FFF, 16'h0001, 1'b0, 1'b0, 1'b1, 16'h8000, 1'b1, 1'b0, 8'd13}, // R13
    '{16'h8000, 16'h8000, 1'b1, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 8'd4},  // R4
    '{16'h8000, 16'h8000, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 8'd3},  // R3
    '{16'h8000, 16'h8000, 1'b0, 1'b1, 1'b1, 16'h8001, 1'b1, 1'b1, 8'd7},  // R7
    '{16'h5000, 16'h5000, 1'b0, 1'b1, 1'b0, 16'h7FFF, 1'b1, 1'b1, 8'd5}   // R5
  };

  logic         clk;
  logic         rst_n;
  logic [W-1:0] op_a;
  logic [W-1:0] op_b;
  logic         sub_sel;
  logic         sat_en;
  logic         sym_lim;
  logic [W-1:0] res;
  logic         ovf;
  logic         sat;

  int  n_checks;
  int  n_fail;
  bit  done;

  sat_addsub #(.WIDTH(W)) u_sat_addsub (
    .clk    (clk),
    .rst_n  (rst_n),
    .op_a   (op_a),
    .op_b   (op_b),
    .sub_sel(sub_sel),
    .sat_en (sat_en),
    .sym_lim(sym_lim),
    .res    (res),
    .ovf    (ovf),
    .sat    (sat)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(string tag, logic [W+1:0] got, logic [W+1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got res=%h ovf=%b sat=%b, expected res=%h ovf=%b sat=%b",
               tag, got[W+1:2], got[1], got[0], exp[W+1:2], exp[1], exp[0]);
    end
  endtask

  task automatic drive(logic [W-1:0] a, logic [W-1:0] b, logic s, logic se, logic sy);
    @(negedge clk);
    op_a = a; op_b = b; sub_sel = s; sat_en = se; sym_lim = sy;
  endtask

  initial begin
    n_checks = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0;
    op_a = '0; op_b = '0; sub_sel = 1'b0; sat_en = 1'b0; sym_lim = 1'b0;
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12 reset state", {res, ovf, sat}, {16'h0000, 1'b0, 1'b0});
    rst_n = 1'b1;

    // Table walk: each row is sampled one negedge after it is driven
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].a, VECS[i].b, VECS[i].sub, VECS[i].sen, VECS[i].sym);
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VECS[i].req, i),
            {res, ovf, sat}, {VECS[i].res, VECS[i].ovf, VECS[i].sat});
    end

    // R11: outputs hold until the next rising edge
    drive(16'h0010, 16'h0020, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check("R11 registered after edge", {res, ovf, sat}, {16'h0030, 1'b0, 1'b0});
    op_a = 16'h7FFF; op_b = 16'h7FFF; sat_en = 1'b1;
    #1;
    check("R11 held before edge", {res, ovf, sat}, {16'h0030, 1'b0, 1'b0});
    @(negedge clk);
    check("R11 updated at edge R5", {res, ovf, sat}, {16'h7FFF, 1'b1, 1'b1});

    // R12: asynchronous reset clears mid-cycle
    #1 rst_n = 1'b0;
    #1;
    check("R12 async clear", {res, ovf, sat}, {16'h0000, 1'b0, 1'b0});
    @(negedge clk);
    check("R12 held in reset", {res, ovf, sat}, {16'h0000, 1'b0, 1'b0});
    rst_n = 1'b1;

    // R13 and R9: wrap mode ignores sym_lim on a negative overflow
    drive(16'h8001, 16'h0002, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    check("R13 sym ignored in wrap", {res, ovf, sat}, {16'h7FFF, 1'b1, 1'b0});

    // R2: negative difference wraps correctly
    drive(16'h0003, 16'h0005, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    check("R2 negative difference", {res, ovf, sat}, {16'hFFFE, 1'b0, 1'b0});

    // R6: saturating subtraction toward the bottom rail
    drive(16'h8005, 16'h0010, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    check("R6 bottom rail", {res, ovf, sat}, {16'h8000, 1'b1, 1'b1});

    // R8: a difference that lands on the bottom code, with the symmetric limit
    drive(16'hFFFF, 16'h7FFF, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    check("R8 subtraction on bottom code", {res, ovf, sat}, {16'h8001, 1'b0, 1'b1});

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule